// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tracking

This block is the receive-side character store of a serial port. Each stored entry keeps a data byte with three error attributes: parity error, framing error and break. The head of the queue is shown on the read side together with its own error attributes, so the line-status logic always sees the error state of the character that will be read next. Software must know that an error sits somewhere in the queue, not only at the head. A running count of entries that carry an error is therefore kept, and a summary flag stays high until the last such entry has been read out.

Both data interfaces use valid/ready. On the read side the consumer may hold `rd_ready` low as long as it likes, and the head stays put. The write side comes from a deserializer that cannot stall. `wr_ready` only reports free space, and a beat offered while `wr_ready` is low is dropped and latched in a sticky overrun flag. A push and a pop can happen in the same cycle. Status pins are plain levels.

Top module: `rx_err_fifo`

## Requirements
- R1: The queue holds at most 64 entries. `level` counts stored entries, and `wr_ready` is low exactly when `level` is 64.
- R2: Bytes leave on `rd_data` in the order they were accepted. A pop happens on a clock edge where `rd_valid` and `rd_ready` are both high.
- R3: `rd_err` shows the error bits of the head entry, with bit 0 = parity, bit 1 = framing and bit 2 = break (the same positions as `wr_err`). After a pop it shows the bits of the next entry.
- R4: When the queue is empty, `empty` is high, `rd_valid` is low, and `rd_err` and `rd_data` are all zeros.
- R5: `err_any` is high exactly when at least one stored entry has a nonzero error field. It stays high until the last such entry has been popped.
- R6: A beat offered with `wr_valid` high while `wr_ready` is low is dropped without changing the stored contents. `overrun` goes high on the following cycle and stays high.
- R7: A `stat_clr` pulse clears `overrun` on the next cycle, unless a drop happens in the same cycle, in which case `overrun` stays set.
- R8: A push and a pop in the same cycle leave `level` unchanged and keep FIFO order.
- R9: After reset the queue is empty, `wr_ready` is high, and `err_any` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Receiver offers a character |
| wr_ready | output | 1 | Space available; a beat offered while low is dropped |
| wr_data | input | 8 | Received byte |
| wr_err | input | 3 | Error bits of the received byte: [0] parity, [1] framing, [2] break |
| rd_valid | output | 1 | Head entry present |
| rd_ready | input | 1 | Consumer takes the head |
| rd_data | output | 8 | Head byte (zero when empty) |
| rd_err | output | 3 | Head error bits (zero when empty) |
| level | output | 7 | Number of stored entries |
| empty | output | 1 | No entries stored |
| err_any | output | 1 | Some stored entry carries an error |
| overrun | output | 1 | Sticky: a beat was dropped because the queue was full |
| stat_clr | input | 1 | Clears the overrun flag |

## Verification
The assertions check on every cycle that the level never exceeds the depth, that `wr_ready` falls when the queue is full, and that the empty head shows zero error bits. They also check that a head carrying an error implies `err_any`, that overrun sets after a drop and clears after `stat_clr`, and that a push with a pop holds the level. Only the bench's scenarios can show FIFO ordering, that the error bits travel with their own bytes, and that `err_any` falls exactly when the last erroneous entry leaves. The same applies to checking that a dropped beat never reaches the output. The reference queue in the bench covers all of these by comparing every output on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ERR_W  = 3;

  typedef struct packed {
    logic [ERR_W-1:0]  err;   // [0] parity, [1] framing, [2] break
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  localparam int unsigned ENTRY_W = $bits(rxq_entry_t);
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 11,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          is_empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  assign level    = cnt;
  assign full     = (cnt == LW'(DEPTH));
  assign is_empty = (cnt == '0);
  assign dout     = mem[rptr];
endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
  parameter int unsigned CW = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (inc && !dec)  cnt <= cnt + 1'b1;
    else if (dec && !inc)  cnt <= cnt - 1'b1;
  end

  assign nonzero = (cnt != '0);
endmodule

// File: rtl/rxq_sticky.sv
module rxq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  wr_err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W-1:0]  rd_err,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              err_any,
  output logic              overrun,
  input  logic              stat_clr
);
  rxq_entry_t in_ent, head;
  logic       full, push, pop, drop;

  assign in_ent.data = wr_data;
  assign in_ent.err  = wr_err;

  assign wr_ready = !full;
  assign rd_valid = !empty;
  assign push     = wr_valid && !full;
  assign pop      = rd_ready && !empty;
  assign drop     = wr_valid && full;

  rxq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .din(in_ent), .dout(head), .level(level), .full(full), .is_empty(empty)
  );

  rxq_errcnt #(.CW(LW)) u_errcnt (
    .clk(clk), .rst_n(rst_n),
    .inc(push && (wr_err != '0)),
    .dec(pop && (head.err != '0)),
    .nonzero(err_any)
  );

  rxq_sticky u_ovr (
    .clk(clk), .rst_n(rst_n), .set(drop), .clr(stat_clr), .flag(overrun)
  );

  assign rd_data = empty ? '0 : head.data;
  assign rd_err  = empty ? '0 : head.err;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [2:0]    rd_err,
  input logic [LW-1:0] level,
  input logic          empty,
  input logic          err_any,
  input logic          overrun,
  input logic          stat_clr
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(DEPTH)) |-> !wr_ready);
  p_empty_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!rd_valid && rd_err == 3'b000));
  p_head_err_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_err != 3'b000) |-> err_any);
  p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> overrun);
  p_ovr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !(wr_valid && !wr_ready)) |=> !overrun);
  p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rd_valid && rd_ready) |=> $stable(level));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_err(rd_err), .level(level),
  .empty(empty), .err_any(err_any), .overrun(overrun), .stat_clr(stat_clr)
);

// File: tb/rx_err_fifo_tb_top.sv
module rx_err_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, rd_ready = 0, stat_clr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_err = 0;
  logic wr_ready, rd_valid, empty, err_any, overrun;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [6:0] level;

  int n_checks = 0, n_fail = 0;
  logic [10:0] q[$];
  bit m_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_err(wr_err), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_err(rd_err), .level(level), .empty(empty),
    .err_any(err_any), .overrun(overrun), .stat_clr(stat_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int sz = q.size();
    bit any = 0;
    foreach (q[i]) if (q[i][10:8] != 0) any = 1;
    chk(level == 7'(sz), "R1 level", level, sz);
    chk(wr_ready == (sz < DEPTH), "R1 wr_ready", wr_ready, sz < DEPTH);
    chk(empty == (sz == 0), "R4 empty", empty, sz == 0);
    chk(rd_valid == (sz != 0), "R4 rd_valid", rd_valid, sz != 0);
    chk(rd_data == (sz ? q[0][7:0] : 8'h0), "R2 rd_data", rd_data, sz ? q[0][7:0] : 0);
    chk(rd_err == (sz ? q[0][10:8] : 3'h0), "R3 rd_err", rd_err, sz ? q[0][10:8] : 0);
    chk(err_any == any, "R5 err_any", err_any, any);
    chk(overrun == m_ovr, "R6/R7 overrun", overrun, m_ovr);
  endtask

  // inputs already applied at negedge; advance one clock and compare
  task automatic step(input bit wv, input logic [7:0] d, input logic [2:0] e,
                      input bit rr, input bit sc);
    bit do_push, do_pop, do_drop;
    wr_valid = wv; wr_data = d; wr_err = e; rd_ready = rr; stat_clr = sc;
    do_push = wv && (q.size() < DEPTH);
    do_drop = wv && (q.size() == DEPTH);
    do_pop  = rr && (q.size() != 0);
    @(posedge clk);
    if (do_pop) void'(q.pop_front());
    if (do_push) q.push_back({e, d});
    if (do_drop) m_ovr = 1;
    else if (sc) m_ovr = 0;
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(empty && wr_ready && !err_any && !overrun && level == 0, "R9 reset", level, 0);
    compare_all();
    // R2 R3 R5: mixed errors, error entry in the middle
    step(1, 8'h11, 3'b000, 0, 0);
    step(1, 8'h22, 3'b010, 0, 0);
    step(1, 8'h33, 3'b000, 0, 0);
    step(1, 8'h44, 3'b101, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    chk(err_any == 1, "R5 flag held while 0x44 stored", err_any, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    chk(err_any == 0, "R5 flag drops after last error popped", err_any, 0);
    step(0, 0, 0, 1, 0);                 // R4 pop on empty does nothing
    // R8 simultaneous push and pop
    step(1, 8'hA0, 3'b001, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 8'(i + 1), 3'(i % 5 == 0 ? 4 : 0), 1, 0);
    chk(level == 1, "R8 level unchanged", level, 1);
    // random traffic
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 1) == 1, 8'($urandom), 3'($urandom_range(0, 3) == 0 ? $urandom : 0),
           $urandom_range(0, 2) == 0, 0);
    // R1 R6 fill, overflow, and stat clear
    while (q.size() < DEPTH) step(1, 8'($urandom), 3'($urandom_range(0, 7) == 0 ? 2 : 0), 0, 0);
    chk(level == 7'(DEPTH) && !wr_ready, "R1 full at 64", level, DEPTH);
    step(1, 8'hEE, 3'b111, 0, 0);
    chk(overrun == 1, "R6 overrun set", overrun, 1);
    step(1, 8'hEF, 3'b000, 1, 0);        // full: push dropped even with pop
    step(0, 0, 0, 0, 0);
    chk(overrun == 1, "R6 overrun sticky", overrun, 1);
    step(1, 8'h5A, 3'b000, 0, 1);        // not full now: accepted, clear
    chk(overrun == 0, "R7 overrun cleared", overrun, 0);
    while (q.size() < DEPTH) step(1, 8'($urandom), 3'b000, 0, 0);
    step(1, 8'h77, 3'b100, 0, 1);        // R7 drop beats clear
    chk(overrun == 1, "R7 set wins over clear", overrun, 1);
    while (q.size() != 0) step(0, 0, 0, 1, 0);
    chk(rd_err == 0 && rd_data == 0 && !err_any, "R4 drained head zero", rd_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule